// File: doc/BRIEF.md
# Compare to condition field

This block is a purely combinational compare unit for an integer pipeline. It takes operand A and a second operand, and from them builds a 4-bit condition field. The second operand is either a register value or a 16-bit immediate, and the immediate is widened to match the compare kind. The field holds a one-hot relation (less, greater or equal) and, in its low bit, a copy of the sticky summary-overflow flag.

The same unit also serves as the recorder for arithmetic and logic results. In that case operand A is compared with zero as a signed number. A 3-bit destination field index travels through the unit unchanged, so the writer downstream knows which field of the condition register to update. The register file and the condition register write are outside the block.

Top module: `cmpu_top`

## Requirements
- R1: The field layout is bit 3 = less-than, bit 2 = greater-than, bit 1 = equal, bit 0 = summary-overflow copy.
- R2: Exactly one of bits 3..1 is set for every input combination.
- R3: Bit 1 (equal) is set whenever operand A and the selected second operand are bitwise identical, for signed and for unsigned compares. Equality takes priority over the other two bits.
- R4: For a signed register compare (isUnsigned=0, useImm=0, recordZero=0), bit 3 is set when A is below B in two's complement. Otherwise, if the operands are not equal, bit 2 is set.
- R5: For an unsigned register compare (isUnsigned=1, useImm=0), less-than uses unsigned magnitude. For example, A=0x00000001 and B=0xFFFFFFFF gives bit 3.
- R6: A signed immediate compare (useImm=1, isUnsigned=0) sign-extends the 16-bit immediate, so 0x8000 acts as 0xFFFF8000.
- R7: An unsigned immediate compare (useImm=1, isUnsigned=1) zero-extends the immediate, so 0x8000 acts as 0x00008000.
- R8: Bit 0 equals the soFlag input and has no effect on bits 3..1.
- R9: With recordZero=1, A is compared with zero as a signed number. opB, imm, isUnsigned and useImm have no effect on the field.
- R10: targetOut always equals targetIdx.
- R11: With useImm=0 the imm input has no effect. With useImm=1 the opB input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand |
| opB | input | 32 | Register second operand |
| imm | input | 16 | Immediate second operand |
| isUnsigned | input | 1 | 1 = unsigned compare, 0 = signed |
| useImm | input | 1 | 1 = take the immediate as second operand |
| recordZero | input | 1 | 1 = record mode: signed compare of A against zero |
| soFlag | input | 1 | Current summary-overflow flag |
| targetIdx | input | 3 | Destination field index |
| condField | output | 4 | LT, GT, EQ, SO |
| targetOut | output | 3 | Destination field index, passed through |

## Verification
The hardest cases are the ones where the signed and unsigned orderings disagree. These occur when exactly one operand has its top bit set, and when an immediate's bit 15 decides between 0xFFFF8000 and 0x00008000. Random 32-bit operands almost never hit equality or these edges. The stimulus therefore mixes directed values with random draws, where A is often copied into B or set to the extended immediate, and the top bits are forced. Record mode is driven with noisy opB, imm and selects, so that any leak from them shows up in the field.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
  typedef struct packed {
    logic signedTest;
    logic takeImm;
    logic takeZero;
  } cmpu_strobe_t;
endpackage

// File: rtl/cmpu_ctrl.sv
module cmpu_ctrl
  import cmpu_pkg::*;
(
  input  logic         isUnsigned,
  input  logic         useImm,
  input  logic         recordZero,
  output cmpu_strobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (recordZero) begin
      strobe.takeZero   = 1'b1;
      strobe.signedTest = 1'b1;
    end else begin
      strobe.signedTest = ~isUnsigned;
      strobe.takeImm    = useImm;
    end
  end

  always_comb begin
    if (recordZero) begin
      AST_RECORD_SIGNED: assert (strobe.signedTest && !strobe.takeImm) // R9
        else $error("record mode must be signed and ignore immediate");
    end
  end
endmodule

// File: rtl/cmpu_dpath.sv
module cmpu_dpath
  import cmpu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [IMM_W-1:0] imm,
  input  logic             soFlag,
  input  cmpu_strobe_t     strobe,
  output logic [3:0]       condField
);
  localparam int EXT_W = WIDTH - IMM_W;

  logic [WIDTH-1:0] immWide;
  logic [WIDTH-1:0] selB;
  logic             isLess;
  logic             isEqual;

  generate
    if (EXT_W > 0) begin : g_ext
      logic fillBit;
      assign fillBit = strobe.signedTest & imm[IMM_W-1];
      assign immWide = {{EXT_W{fillBit}}, imm};
    end else begin : g_noext
      assign immWide = imm[WIDTH-1:0];
    end
  endgenerate

  always_comb begin
    if (strobe.takeZero)      selB = '0;
    else if (strobe.takeImm)  selB = immWide;
    else                      selB = opB;
  end

  always_comb begin
    isEqual = (opA == selB);
    if (strobe.signedTest) isLess = ($signed(opA) < $signed(selB));
    else                   isLess = (opA < selB);
  end

  always_comb begin
    condField    = 4'b0000;
    condField[0] = soFlag;
    if (isEqual)     condField[1] = 1'b1;
    else if (isLess) condField[3] = 1'b1;
    else             condField[2] = 1'b1;
  end

  always_comb begin
    AST_ONE_RELATION: assert ($countones(condField[3:1]) == 1) // R2
      else $error("relation bits not one-hot");
    if (strobe.takeImm && !strobe.takeZero && strobe.signedTest) begin
      AST_IMM_SIGN_FILL: assert (selB[WIDTH-1] == imm[IMM_W-1]) // R6
        else $error("immediate not sign-extended");
    end
    if (strobe.takeImm && !strobe.takeZero && !strobe.signedTest) begin
      AST_IMM_ZERO_FILL: assert (selB[WIDTH-1] == 1'b0) // R7
        else $error("immediate not zero-extended");
    end
  end
endmodule

// File: rtl/cmpu_top.sv
module cmpu_top
  import cmpu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16,
  parameter int IDX_W = 3
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [IMM_W-1:0] imm,
  input  logic             isUnsigned,
  input  logic             useImm,
  input  logic             recordZero,
  input  logic             soFlag,
  input  logic [IDX_W-1:0] targetIdx,
  output logic [3:0]       condField,
  output logic [IDX_W-1:0] targetOut
);
  cmpu_strobe_t strobe;

  cmpu_ctrl u_ctrl (
    .isUnsigned(isUnsigned),
    .useImm(useImm),
    .recordZero(recordZero),
    .strobe(strobe)
  );

  cmpu_dpath #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_dpath (
    .opA(opA),
    .opB(opB),
    .imm(imm),
    .soFlag(soFlag),
    .strobe(strobe),
    .condField(condField)
  );

  assign targetOut = targetIdx;

  always_comb begin
    AST_SO_COPY: assert (condField[0] == soFlag) // R8
      else $error("low bit differs from summary flag");
    if (recordZero && opA == '0) begin
      AST_ZERO_RECORD_EQ: assert (condField == {3'b001, soFlag}) // R9
        else $error("zero result not recorded as equal");
    end
    if (recordZero && opA[WIDTH-1]) begin
      AST_NEG_RECORD_LT: assert (condField[3]) // R9
        else $error("negative result not recorded as less");
    end
  end
endmodule

// File: tb/cmpu_top_test.sv
module cmpu_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [15:0] imm = '0;
  logic        isUnsigned = 1'b0, useImm = 1'b0, recordZero = 1'b0, soFlag = 1'b0;
  logic [2:0]  targetIdx = '0;
  logic [3:0]  condField;
  logic [2:0]  targetOut;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cmpu_top uut (
    .opA(opA), .opB(opB), .imm(imm), .isUnsigned(isUnsigned), .useImm(useImm),
    .recordZero(recordZero), .soFlag(soFlag), .targetIdx(targetIdx),
    .condField(condField), .targetOut(targetOut)
  );

  function automatic logic [3:0] refField(logic [31:0] a, logic [31:0] b, logic [15:0] im,
                                          logic uns, logic ui, logic rz, logic so);
    longint av, bv;
    logic [3:0] f;
    if (rz) begin
      av = longint'($signed(a)); bv = 0;
    end else begin
      if (ui) bv = uns ? longint'(im) : longint'($signed(im));
      else    bv = uns ? longint'(b)  : longint'($signed(b));
      av = uns ? longint'(a) : longint'($signed(a));
    end
    if (av == bv)     f = 4'b0010;
    else if (av < bv) f = 4'b1000;
    else              f = 4'b0100;
    f[0] = so;
    return f;
  endfunction

  task automatic apply(input string tag, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic uns, input logic ui,
                       input logic rz, input logic so, input logic [2:0] ti);
    logic [3:0] exp;
    @(posedge clk);
    opA = a; opB = b; imm = im; isUnsigned = uns; useImm = ui;
    recordZero = rz; soFlag = so; targetIdx = ti;
    exp = refField(a, b, im, uns, ui, rz, so);
    @(negedge clk);
    total++;
    if (condField !== exp) begin
      bad++;
      $display("FAIL %s field actual=%b expected=%b", tag, condField, exp);
    end
    total++;
    if (targetOut !== ti) begin
      bad++;
      $display("FAIL R10 index actual=%0d expected=%0d", targetOut, ti);
    end
  endtask

  task automatic expectField(input string tag, input logic [3:0] want);
    total++;
    if (condField !== want) begin
      bad++;
      $display("FAIL %s literal actual=%b expected=%b", tag, condField, want);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectField("R1 reset zero-equal", 4'b0010);

    apply("R4 signed less", 32'hFFFF_FFFF, 32'h1, '0, 0, 0, 0, 0, 3'd1);
    expectField("R1 R4 layout LT", 4'b1000);
    apply("R4 signed greater", 32'h5, 32'h8000_0000, '0, 0, 0, 0, 1, 3'd2);
    expectField("R1 R8 layout GT+SO", 4'b0101);
    apply("R5 unsigned less", 32'h1, 32'hFFFF_FFFF, '0, 1, 0, 0, 0, 3'd3);
    expectField("R5 literal", 4'b1000);
    apply("R5 unsigned greater", 32'h8000_0000, 32'h5, '0, 1, 0, 0, 0, 3'd4);
    apply("R3 equal signed", 32'hDEAD_BEEF, 32'hDEAD_BEEF, '0, 0, 0, 0, 0, 3'd5);
    expectField("R3 literal", 4'b0010);
    apply("R3 equal unsigned", 32'h8000_0000, 32'h8000_0000, '0, 1, 0, 0, 1, 3'd6);
    apply("R6 sign-extended imm", 32'hFFFF_8000, 32'h0, 16'h8000, 0, 1, 0, 0, 3'd7);
    expectField("R6 literal", 4'b0010);
    apply("R7 zero-extended imm", 32'h0000_8000, 32'h0, 16'h8000, 1, 1, 0, 0, 3'd0);
    expectField("R7 literal", 4'b0010);
    apply("R7 unsigned imm below", 32'hFFFF_8000, 32'h0, 16'h8000, 1, 1, 0, 0, 3'd1);
    expectField("R7 greater literal", 4'b0100);
    apply("R11 imm ignored", 32'h10, 32'h10, 16'h1234, 0, 0, 0, 0, 3'd2);
    expectField("R11 literal", 4'b0010);
    apply("R11 opB ignored", 32'h7, 32'h0, 16'h0007, 1, 1, 0, 0, 3'd2);
    expectField("R11 literal imm", 4'b0010);
    apply("R9 record zero", 32'h0, 32'h55, 16'hFFFF, 1, 1, 1, 1, 3'd3);
    expectField("R9 literal eq", 4'b0011);
    apply("R9 record negative", 32'h8000_0000, 32'h0, 16'h0, 1, 0, 1, 0, 3'd3);
    expectField("R9 literal lt", 4'b1000);
    apply("R9 record positive", 32'h1, 32'hFFFF_FFFF, 16'h7FFF, 1, 1, 1, 0, 3'd3);
    expectField("R9 literal gt", 4'b0100);
    apply("R8 so no effect", 32'h1, 32'h1, '0, 0, 0, 0, 1, 3'd0);
    expectField("R8 literal", 4'b0011);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      logic [15:0] im;
      logic uns, ui, rz, so;
      a = $urandom; b = $urandom; im = $urandom;
      uns = $urandom; ui = $urandom; rz = ($urandom % 5) == 0; so = $urandom;
      case ($urandom % 6)
        0: b = a;
        1: a = uns ? {16'h0, im} : {{16{im[15]}}, im};
        2: begin a[31] = 1'b1; b[31] = 1'b0; end
        3: begin a[31] = 1'b0; b[31] = 1'b1; end
        4: if (rz) a = '0;
        default: ;
      endcase
      apply("R2 R3 R4 R5 R6 R7 R9 random", a, b, im, uns, ui, rz, so, 3'($urandom));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule